// File: doc/BRIEF.md
# Paged Audio Controller Register File

This block is the host-facing register file of a three-channel audio DMA controller with two playback channels and one record channel. It decodes a 256-byte I/O window and accepts 8-, 16- and 32-bit reads and writes. Narrow writes to the control, serial-control and codec registers are merged into the addressed byte lanes of the 32-bit register. Write data is right-justified on `wdata_i`, and the low two address bits select the starting lane.

A 4-bit page register relocates offsets 0x30 to 0x3F. Within that window the effective address is the offset ORed with the page shifted left by eight bits. Page 0xC reaches the frame address and frame count registers of both playback channels. Page 0xD reaches the record channel and an unimplemented fourth slot. The block also holds the interrupt status register. It sets a channel's pending bit from a per-channel event input and drives one level-sensitive interrupt line. Host reads are registered and return one cycle after the request.

Top module: `apr_regfile`

## Requirements
- R1: After reset, control reads 0x00000001, status reads 0x00000060, and the page, codec, serial-control, sample-count and frame registers read 0. `irq_o` is low.
- R2: A write of any size to control (0x00), serial control (0x20) or codec (0x10) replaces only the byte lanes it covers. The lanes start at lane addr[1:0], span 1, 2 or 4 bytes for size 0, 1 or 2, and take their data from the low bytes of `wdata_i`. All other lanes keep their value.
- R3: A read request yields `rvalid_o` high on the next cycle. `rdata_o` then holds the 32-bit register value shifted right by addr[1:0]×8 and masked to the access width (8, 16 or 32 bits). Bits above that width are zero.
- R4: Any write that covers lane 0 of offset 0x0C loads the page register with `wdata_i[3:0]`. A read of that offset returns the page zero-extended.
- R5: For offsets 0x30–0x3F the effective address is {page, offset}. The channel registers sit at these addresses: 0xC30 first-playback frame address, 0xC34 its frame count, 0xC38 second-playback frame address, 0xC3C its frame count, 0xD30 record frame address, 0xD34 record frame count. Only 32-bit writes at lane 0 load a frame register. Narrower writes leave it unchanged.
- R6: Reads from unmapped effective addresses, including 0xD38, 0xD3C, other pages in the window and offsets 0x40 and above, return all ones within the access width. Writes to them change nothing.
- R7: The sample-count registers sit at 0x24 (first playback), 0x28 (second playback) and 0x2C (record). A 16- or 32-bit write at lane 0 loads only bits 15:0. Byte writes are ignored. Bits 31:16 hold the current count, which reads zero because nothing in this block advances it.
- R8: Status (0x04) reads bit 31 = OR of the pending bits, bits 6:5 = 2'b11, bit 2 = first-playback pending, bit 1 = second-playback pending, bit 0 = record pending, and every other bit zero. Host writes to status have no effect.
- R9: `chan_evt_i` bit 0 (first playback), bit 1 (second playback) and bit 2 (record) set that channel's pending bit at the next clock edge. This happens only while its serial-control enable is set: bit 8, 9 or 10 respectively.
- R10: A serial-control write that takes a channel's enable from 1 to 0 clears that channel's pending bit at the same edge. It wins over an event for that channel in the same cycle.
- R11: `irq_o` is high exactly when at least one pending bit is set. It changes at the same edge as the pending bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Host access request, one cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| size_i | input | 2 | Access width: 0 byte, 1 half, 2 word |
| addr_i | input | 8 | Byte offset within the I/O window |
| wdata_i | input | 32 | Write data, right-justified |
| rdata_o | output | 32 | Read data, right-justified |
| rvalid_o | output | 1 | Read data valid |
| chan_evt_i | input | 3 | Per-channel completion event |
| irq_o | output | 1 | Level interrupt |

## Verification
Read data is due on the cycle after its request, because one register stands between the decode and `rdata_o`. A write or event changes the state at the edge that samples it. The scoreboard queues the expected word when it drives a read. It pops that word on the next falling edge, the first falling edge at which `rvalid_o` can be high. Interrupt and pending-bit results are sampled on the falling edge after the pulse, and are also read back through the status register. A read issued in the same cycle as a write would return the pre-write value, so the bench never overlaps the two.

// File: rtl/apr_pkg.sv
package apr_pkg;
  localparam int DW     = 32;
  localparam int NB     = DW / 8;
  localparam int PAGE_W = 4;
  localparam int OFS_W  = 8;
  localparam int EA_W   = OFS_W + PAGE_W;
  localparam int NCH    = 3;
  localparam int CNT_W  = 16;

  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_HALF = 2'd1;
  localparam logic [1:0] SZ_WORD = 2'd2;

  typedef enum logic [3:0] {
    SEL_NONE, SEL_CTRL, SEL_STAT, SEL_PAGE, SEL_CODEC,
    SEL_SCTL, SEL_SCNT, SEL_FADDR, SEL_FCNT
  } reg_sel_e;

  function automatic logic [NB-1:0] lane_en(input logic [1:0] sz, input logic [1:0] lane);
    logic [NB-1:0] base;
    case (sz)
      SZ_BYTE: base = NB'(1);
      SZ_HALF: base = NB'(3);
      default: base = '1;
    endcase
    return base << lane;
  endfunction

  function automatic logic [DW-1:0] size_mask(input logic [1:0] sz);
    logic [DW-1:0] m;
    case (sz)
      SZ_BYTE: m = DW'(8'hFF);
      SZ_HALF: m = DW'(16'hFFFF);
      default: m = '1;
    endcase
    return m;
  endfunction
endpackage

// File: rtl/apr_decode.sv
module apr_decode
  import apr_pkg::*;
(
  input  logic [OFS_W-1:0]  addr_i,
  input  logic [PAGE_W-1:0] page_i,
  output reg_sel_e          sel_o,
  output logic [1:0]        ch_o,
  output logic [1:0]        lane_o
);
  logic [EA_W-1:0] ea;
  logic [EA_W-1:0] ea_word;

  // paged window 0x30..0x3F
  assign ea      = (addr_i[OFS_W-1:4] == 4'h3) ? {page_i, addr_i} : {{PAGE_W{1'b0}}, addr_i};
  assign ea_word = {ea[EA_W-1:2], 2'b00};
  assign lane_o  = ea[1:0];

  always_comb begin
    sel_o = SEL_NONE;
    ch_o  = 2'd0;
    case (ea_word)
      EA_W'(12'h000): sel_o = SEL_CTRL;
      EA_W'(12'h004): sel_o = SEL_STAT;
      EA_W'(12'h00C): sel_o = SEL_PAGE;
      EA_W'(12'h010): sel_o = SEL_CODEC;
      EA_W'(12'h020): sel_o = SEL_SCTL;
      EA_W'(12'h024): begin sel_o = SEL_SCNT;  ch_o = 2'd0; end
      EA_W'(12'h028): begin sel_o = SEL_SCNT;  ch_o = 2'd1; end
      EA_W'(12'h02C): begin sel_o = SEL_SCNT;  ch_o = 2'd2; end
      EA_W'(12'hC30): begin sel_o = SEL_FADDR; ch_o = 2'd0; end
      EA_W'(12'hC34): begin sel_o = SEL_FCNT;  ch_o = 2'd0; end
      EA_W'(12'hC38): begin sel_o = SEL_FADDR; ch_o = 2'd1; end
      EA_W'(12'hC3C): begin sel_o = SEL_FCNT;  ch_o = 2'd1; end
      EA_W'(12'hD30): begin sel_o = SEL_FADDR; ch_o = 2'd2; end
      EA_W'(12'hD34): begin sel_o = SEL_FCNT;  ch_o = 2'd2; end
      default: ;
    endcase
  end
endmodule

// File: rtl/apr_lane_merge.sv
module apr_lane_merge
  import apr_pkg::*;
(
  input  logic [DW-1:0] cur_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [1:0]    lane_i,
  input  logic [NB-1:0] be_i,
  output logic [DW-1:0] merged_o
);
  logic [DW-1:0] shifted;
  assign shifted = wdata_i << {lane_i, 3'b000};

  for (genvar b = 0; b < NB; b++) begin : g_lane
    assign merged_o[8*b +: 8] = be_i[b] ? shifted[8*b +: 8] : cur_i[8*b +: 8];
  end
endmodule

// File: rtl/apr_chan_regs.sv
module apr_chan_regs
  import apr_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          scnt_we_i,
  input  logic          faddr_we_i,
  input  logic          fcnt_we_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] scnt_o,
  output logic [DW-1:0] faddr_o,
  output logic [DW-1:0] fcnt_o
);
  logic [CNT_W-1:0] prog_q;
  logic [DW-1:0]    faddr_q, fcnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prog_q  <= '0;
      faddr_q <= '0;
      fcnt_q  <= '0;
    end else begin
      if (scnt_we_i)  prog_q  <= wdata_i[CNT_W-1:0];
      if (faddr_we_i) faddr_q <= wdata_i;
      if (fcnt_we_i)  fcnt_q  <= wdata_i;
    end
  end

  // current count is advanced by the DMA engine, outside this block
  assign scnt_o  = {{(DW-CNT_W){1'b0}}, prog_q};
  assign faddr_o = faddr_q;
  assign fcnt_o  = fcnt_q;

  assert_fcnt_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fcnt_we_i |=> $stable(fcnt_o));
  assert_scnt_load_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    scnt_we_i |=> scnt_o == {{(DW-CNT_W){1'b0}}, $past(wdata_i[CNT_W-1:0])});
endmodule

// File: rtl/apr_irq.sv
module apr_irq
  import apr_pkg::*;
(
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [NCH-1:0] evt_i,
  input  logic [NCH-1:0] en_i,
  input  logic [NCH-1:0] en_fall_i,
  output logic [NCH-1:0] pend_o,
  output logic           irq_o
);
  logic [NCH-1:0] pend_q;

  // disable edge wins over a same-cycle event
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= '0;
    else         pend_q <= (pend_q | (evt_i & en_i)) & ~en_fall_i;
  end

  assign pend_o = pend_q;
  assign irq_o  = |pend_q;

  for (genvar c = 0; c < NCH; c++) begin : g_chk
    assert_pend_set_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(pend_q[c]) |-> $past(evt_i[c] && en_i[c]));
    assert_pend_clr_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $past(en_fall_i[c]) |-> !pend_q[c]);
  end
endmodule

// File: rtl/apr_regfile.sv
module apr_regfile
  import apr_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic             we_i,
  input  logic [1:0]       size_i,
  input  logic [OFS_W-1:0] addr_i,
  input  logic [DW-1:0]    wdata_i,
  output logic [DW-1:0]    rdata_o,
  output logic             rvalid_o,
  input  logic [NCH-1:0]   chan_evt_i,
  output logic             irq_o
);
  localparam logic [DW-1:0] CTRL_RST    = DW'(1);
  localparam logic [DW-1:0] STAT_FIXED  = DW'(8'h60);
  localparam int            EN_LSB      = 8;
  localparam int            STAT_IRQ    = DW - 1;
  localparam int            NMRG        = 3;

  logic [DW-1:0]     ctrl_q, sctl_q, codec_q;
  logic [PAGE_W-1:0] page_q;
  reg_sel_e          sel;
  logic [1:0]        ch, lane;
  logic [NB-1:0]     be;
  logic              wr, rd, full_wr, scnt_wr;
  logic [NCH-1:0]    en, en_fall, pend;
  logic [DW-1:0]     stat_word, rd_word, rd_val, rdata_q;
  logic              rvalid_q;
  logic [NMRG-1:0][DW-1:0] mrg_cur, mrg_out;
  logic [NCH-1:0][DW-1:0]  scnt, faddr, fcnt;

  apr_decode u_decode (
    .addr_i (addr_i),
    .page_i (page_q),
    .sel_o  (sel),
    .ch_o   (ch),
    .lane_o (lane)
  );

  assign wr      = req_i & we_i;
  assign rd      = req_i & ~we_i;
  assign be      = lane_en(size_i, lane);
  assign full_wr = wr && (size_i == SZ_WORD) && (lane == 2'd0);
  assign scnt_wr = wr && (sel == SEL_SCNT) && (lane == 2'd0) && (size_i != SZ_BYTE);

  // lane merge: 0 control, 1 serial control, 2 codec
  assign mrg_cur = {codec_q, sctl_q, ctrl_q};
  for (genvar m = 0; m < NMRG; m++) begin : g_mrg
    apr_lane_merge u_merge (
      .cur_i    (mrg_cur[m]),
      .wdata_i  (wdata_i),
      .lane_i   (lane),
      .be_i     (be),
      .merged_o (mrg_out[m])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q  <= CTRL_RST;
      sctl_q  <= '0;
      codec_q <= '0;
      page_q  <= '0;
    end else if (wr) begin
      case (sel)
        SEL_CTRL:  ctrl_q  <= mrg_out[0];
        SEL_SCTL:  sctl_q  <= mrg_out[1];
        SEL_CODEC: codec_q <= mrg_out[2];
        SEL_PAGE:  if (be[0]) page_q <= wdata_i[PAGE_W-1:0];
        default: ;
      endcase
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    apr_chan_regs u_chan (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .scnt_we_i  (scnt_wr && (ch == 2'(c))),
      .faddr_we_i (full_wr && (sel == SEL_FADDR) && (ch == 2'(c))),
      .fcnt_we_i  (full_wr && (sel == SEL_FCNT) && (ch == 2'(c))),
      .wdata_i    (wdata_i),
      .scnt_o     (scnt[c]),
      .faddr_o    (faddr[c]),
      .fcnt_o     (fcnt[c])
    );
  end

  assign en      = sctl_q[EN_LSB +: NCH];
  assign en_fall = (wr && sel == SEL_SCTL) ? (en & ~mrg_out[1][EN_LSB +: NCH]) : '0;

  apr_irq u_irq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .evt_i     (chan_evt_i),
    .en_i      (en),
    .en_fall_i (en_fall),
    .pend_o    (pend),
    .irq_o     (irq_o)
  );

  // pending bits are packed in reverse channel order
  always_comb begin
    stat_word = STAT_FIXED;
    for (int c = 0; c < NCH; c++) stat_word[NCH-1-c] = pend[c];
    stat_word[STAT_IRQ] = irq_o;
  end

  always_comb begin
    case (sel)
      SEL_CTRL:  rd_word = ctrl_q;
      SEL_STAT:  rd_word = stat_word;
      SEL_PAGE:  rd_word = DW'(page_q);
      SEL_CODEC: rd_word = codec_q;
      SEL_SCTL:  rd_word = sctl_q;
      SEL_SCNT:  rd_word = scnt[ch];
      SEL_FADDR: rd_word = faddr[ch];
      SEL_FCNT:  rd_word = fcnt[ch];
      default:   rd_word = '1;
    endcase
  end

  assign rd_val = (rd_word >> {lane, 3'b000}) & size_mask(size_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= rd;
      if (rd) rdata_q <= rd_val;
    end
  end

  assign rdata_o  = rdata_q;
  assign rvalid_o = rvalid_q;

  assert_ctrl_lane_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && sel == SEL_CTRL && size_i == SZ_BYTE && lane == 2'd1)
      |=> (ctrl_q[7:0] == $past(ctrl_q[7:0])) && (ctrl_q[15:8] == $past(wdata_i[7:0])));
  assert_read_latency_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd |=> rvalid_o);
  assert_page_load_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && sel == SEL_PAGE && lane == 2'd0) |=> page_q == $past(wdata_i[PAGE_W-1:0]));
  assert_unmapped_ones_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd && sel == SEL_NONE && size_i == SZ_WORD && lane == 2'd0) |=> rdata_o == '1);
endmodule

// File: tb/tb_apr_regfile.sv
module tb_apr_regfile;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [1:0]  size = 2'd0;
  logic [7:0]  addr = 8'h00;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        rvalid;
  logic [2:0]  evt = 3'b000;
  logic        irq;
  int          n_vec = 0, n_bad = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #5 clk = ~clk;

  apr_regfile dut (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req), .we_i(we), .size_i(size),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .rvalid_o(rvalid),
    .chan_evt_i(evt), .irq_o(irq)
  );

  // monitor: pops expected read data when the design presents it
  always @(negedge clk) begin : mon
    logic [31:0] e;
    string t;
    if (rvalid) begin
      n_vec++;
      if (exp_q.size() == 0) begin
        n_bad++;
        $display("FAIL R3 unexpected read data act=%h exp=none", rdata);
      end else begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (rdata !== e) begin
          n_bad++;
          $display("FAIL %s act=%h exp=%h", t, rdata, e);
        end
      end
    end
  end

  task automatic wr(input logic [1:0] sz, input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b1; size = sz; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] sz, input logic [7:0] a, input logic [31:0] e, input string t);
    @(negedge clk);
    exp_q.push_back(e); tag_q.push_back(t);
    req = 1'b1; we = 1'b0; size = sz; addr = a;
    @(negedge clk);
    req = 1'b0;
  endtask

  task automatic chk_irq(input logic e, input string t);
    @(negedge clk);
    n_vec++;
    if (irq !== e) begin
      n_bad++;
      $display("FAIL %s irq act=%b exp=%b", t, irq, e);
    end
  endtask

  task automatic pulse(input logic [2:0] ev);
    @(negedge clk);
    evt = ev;
    @(negedge clk);
    evt = 3'b000;
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_vec++; n_bad++;
    $display("FAIL watchdog act=hung exp=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;

    // R1 reset state
    chk_irq(1'b0, "R1 reset irq");
    rd(2'd2, 8'h00, 32'h0000_0001, "R1 ctrl reset");
    rd(2'd2, 8'h04, 32'h0000_0060, "R1 status reset");
    rd(2'd2, 8'h0C, 32'h0, "R1 page reset");
    rd(2'd2, 8'h10, 32'h0, "R1 codec reset");
    rd(2'd2, 8'h20, 32'h0, "R1 sctl reset");
    rd(2'd2, 8'h24, 32'h0, "R1 scount reset");

    // R2 / R3 lane merge and lane read
    wr(2'd0, 8'h02, 32'h0000_00AB);
    rd(2'd2, 8'h00, 32'h00AB_0001, "R2 ctrl byte lane2");
    rd(2'd0, 8'h02, 32'h0000_00AB, "R3 byte read lane2");
    wr(2'd1, 8'h02, 32'h0000_1234);
    rd(2'd2, 8'h00, 32'h1234_0001, "R2 ctrl upper half");
    wr(2'd1, 8'h00, 32'h0000_BEEF);
    rd(2'd2, 8'h00, 32'h1234_BEEF, "R2 ctrl lower half");
    wr(2'd2, 8'h00, 32'hCAFE_F00D);
    rd(2'd1, 8'h02, 32'h0000_CAFE, "R3 half read upper");
    wr(2'd2, 8'h10, 32'h0000_A5C3);
    wr(2'd0, 8'h11, 32'h0000_007E);
    rd(2'd2, 8'h10, 32'h0000_7EC3, "R2 codec byte lane1");

    // R9 / R10 / R11 interrupt logic
    wr(2'd0, 8'h21, 32'h0000_0007);
    rd(2'd2, 8'h20, 32'h0000_0700, "R2 sctl byte lane1");
    pulse(3'b111);
    chk_irq(1'b1, "R11 irq on pending");
    rd(2'd2, 8'h04, 32'h8000_0067, "R9 all pending");
    wr(2'd0, 8'h21, 32'h0000_0005);
    rd(2'd2, 8'h04, 32'h8000_0065, "R10 second playback cleared");
    wr(2'd0, 8'h21, 32'h0000_0000);
    rd(2'd2, 8'h04, 32'h0000_0060, "R10 all cleared");
    chk_irq(1'b0, "R11 irq low");
    pulse(3'b111);
    rd(2'd2, 8'h04, 32'h0000_0060, "R9 events while disabled");
    chk_irq(1'b0, "R9 irq stays low");
    wr(2'd0, 8'h21, 32'h0000_0001);
    pulse(3'b111);
    rd(2'd2, 8'h04, 32'h8000_0064, "R9 only first playback");
    rd(2'd0, 8'h07, 32'h0000_0080, "R3 status byte lane3");
    wr(2'd2, 8'h04, 32'h0000_0000);
    rd(2'd2, 8'h04, 32'h8000_0064, "R8 status write ignored");
    wr(2'd2, 8'h20, 32'h0000_0100);
    rd(2'd2, 8'h04, 32'h8000_0064, "R10 enable kept no clear");
    wr(2'd2, 8'h20, 32'h0000_0000);
    rd(2'd2, 8'h04, 32'h0000_0060, "R10 word write clears");
    wr(2'd2, 8'h20, 32'h0000_0100);
    @(negedge clk);
    evt = 3'b001; req = 1'b1; we = 1'b1; size = 2'd2; addr = 8'h20; wdata = 32'h0;
    @(negedge clk);
    evt = 3'b000; req = 1'b0; we = 1'b0;
    rd(2'd2, 8'h04, 32'h0000_0060, "R10 clear wins over event");
    chk_irq(1'b0, "R11 irq after clear win");

    // R4 page register
    wr(2'd2, 8'h0C, 32'hFFFF_FFF3);
    rd(2'd2, 8'h0C, 32'h0000_0003, "R4 page low bits");
    rd(2'd2, 8'h30, 32'hFFFF_FFFF, "R6 unmapped page window");

    // R5 frame registers through paging
    wr(2'd2, 8'h0C, 32'h0000_000C);
    wr(2'd2, 8'h30, 32'h1111_1111);
    wr(2'd2, 8'h34, 32'h2222_0022);
    wr(2'd2, 8'h38, 32'h3333_3333);
    wr(2'd2, 8'h3C, 32'h4444_4444);
    rd(2'd2, 8'h30, 32'h1111_1111, "R5 first faddr");
    rd(2'd2, 8'h34, 32'h2222_0022, "R5 first fcnt");
    rd(2'd1, 8'h36, 32'h0000_2222, "R5 fcnt upper half");
    rd(2'd2, 8'h38, 32'h3333_3333, "R5 second faddr");
    rd(2'd2, 8'h3C, 32'h4444_4444, "R5 second fcnt");
    wr(2'd1, 8'h30, 32'h0000_9999);
    rd(2'd2, 8'h30, 32'h1111_1111, "R5 narrow frame write ignored");
    wr(2'd2, 8'h0C, 32'h0000_000D);
    wr(2'd2, 8'h30, 32'h5555_5555);
    wr(2'd2, 8'h34, 32'h6666_6666);
    wr(2'd2, 8'h38, 32'h7777_7777);
    wr(2'd2, 8'h3C, 32'h8888_8888);
    rd(2'd2, 8'h30, 32'h5555_5555, "R5 record faddr");
    rd(2'd2, 8'h34, 32'h6666_6666, "R5 record fcnt");
    rd(2'd2, 8'h38, 32'hFFFF_FFFF, "R6 phantom faddr");
    rd(2'd2, 8'h3C, 32'hFFFF_FFFF, "R6 phantom fcnt");
    rd(2'd2, 8'h00, 32'hCAFE_F00D, "R5 page ignored outside window");
    wr(2'd2, 8'h0C, 32'h0000_000C);
    rd(2'd2, 8'h30, 32'h1111_1111, "R5 first faddr kept");
    rd(2'd2, 8'h38, 32'h3333_3333, "R5 second faddr kept");

    // R7 sample counts
    wr(2'd2, 8'h24, 32'hABCD_1234);
    rd(2'd2, 8'h24, 32'h0000_1234, "R7 word write low half");
    wr(2'd1, 8'h28, 32'h0000_5678);
    rd(2'd2, 8'h28, 32'h0000_5678, "R7 half write");
    wr(2'd0, 8'h2C, 32'h0000_0099);
    rd(2'd2, 8'h2C, 32'h0000_0000, "R7 byte write ignored");
    wr(2'd2, 8'h2C, 32'hFFFF_0042);
    rd(2'd2, 8'h2C, 32'h0000_0042, "R7 record count");
    rd(2'd1, 8'h26, 32'h0000_0000, "R7 current count upper");

    // R6 unmapped
    rd(2'd2, 8'h40, 32'hFFFF_FFFF, "R6 word unmapped");
    rd(2'd0, 8'h80, 32'h0000_00FF, "R6 byte unmapped");
    rd(2'd1, 8'hFE, 32'h0000_FFFF, "R6 half unmapped");
    wr(2'd2, 8'h44, 32'h0000_0000);
    rd(2'd2, 8'h00, 32'hCAFE_F00D, "R6 unmapped write ignored");

    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) begin
      n_vec++; n_bad++;
      $display("FAIL R3 missing read data act=%0d exp=0", exp_q.size());
    end
    finish_run();
  end
endmodule